// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block produces a single pulse of programmable length whenever one of its two trigger inputs sees a qualifying edge. The pulse length is a count of system clock cycles, and a digital counter measures it in place of an analog timing network. The true output sits low and the complementary output sits high between pulses. During a pulse the two outputs swap levels.

There are two trigger inputs with opposite edge polarity, and each one is gated by the level of the other. A rise on `trigRise` counts only while `trigFall` is high. A fall on `trigFall` counts only while `trigRise` is low. A qualifying edge that arrives during a pulse reloads the counter, so the pulse then ends one full width after the most recent trigger. The active-low `clearN` input ends a pulse and blocks all triggers for as long as it is held low.

All three control inputs pass through two-flop synchronisers, so every input takes effect on the third rising clock edge after it changes. A synchronous reset returns the block to idle.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs return to idle (`pulseQ`=0, `pulseQn`=1) on that edge. This applies even in the middle of a pulse. After `rst` is released, the block stays idle until a qualifying edge arrives.
- R2: A 0→1 change on `trigRise` while `trigFall` is held at 1 starts a pulse. `pulseQ` goes high after the third rising clock edge that follows the input change. A 1→0 change on `trigRise` never starts a pulse.
- R3: A 1→0 change on `trigFall` while `trigRise` is held at 0 starts a pulse, with the same three-edge latency as R2. A 0→1 change on `trigFall` never starts a pulse.
- R4: `trigFall` edges have no effect while `trigRise` is held at 1. `trigRise` edges have no effect while `trigFall` is held at 0.
- R5: A pulse lasts exactly `pulseWidth` clock cycles. A `pulseWidth` value of 0 gives a pulse of one cycle.
- R6: A qualifying edge that arrives during a pulse restarts the count. The pulse stays high without a gap until `pulseWidth` cycles after the last trigger is loaded. This also holds when the reload falls on the cycle in which the count would have expired.
- R7: When `clearN` goes low, `pulseQ` goes low on the third rising edge after the change, and an active pulse is cut short.
- R8: Qualifying edges have no effect while `clearN` is low. Releasing `clearN` does not start a pulse by itself.
- R9: If a clear and a qualifying edge reach the control logic in the same cycle, the clear wins and no pulse starts.
- R10: `pulseQn` is always the inverse of `pulseQ`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trigRise | input | 1 | Trigger that acts on rising edges; qualified by `trigFall` being high |
| trigFall | input | 1 | Trigger that acts on falling edges; qualified by `trigRise` being low |
| clearN | input | 1 | Clear, active low; ends the pulse and blocks triggers |
| pulseWidth | input | CNT_W | Pulse length in clock cycles; 0 is treated as 1 |
| pulseQ | output | 1 | True pulse output, high during the pulse |
| pulseQn | output | 1 | Complementary pulse output, low during the pulse |

## Verification
Two pairs of functions can fall on the same clock edge, and the bench drives each pair into coincidence on purpose.

- **Clear against trigger.** The bench changes `clearN` and `trigRise` in the same half-cycle. Both then cross their synchronisers together and reach the control logic in one cycle. The check passes only if no pulse appears at all.
- **Reload against expiry.** The bench spaces two triggers so that the second reload lands on the edge where the first count would run out. The bench counts high cycles and falling transitions on `pulseQ`. It expects exactly one falling transition and a combined length equal to the trigger spacing plus the width.

// File: rtl/retrig_oneshot_pkg.sv
package retrig_oneshot_pkg;

  // Strobes from the control path to the datapath, valid for one cycle.
  typedef struct packed {
    logic load;   // reload the width counter
    logic kill;   // force the counter to zero
  } osStrobe_t;

endpackage

// File: rtl/retrig_oneshot_sync.sv
module retrig_oneshot_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/retrig_oneshot_dp.sv
module retrig_oneshot_dp
  import retrig_oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigRiseIn,
  input  logic             trigFallIn,
  input  logic             clearNIn,
  input  logic [CNT_W-1:0] widthIn,
  input  osStrobe_t        ctlStb,
  output logic             riseLvl,
  output logic             risePrev,
  output logic             fallLvl,
  output logic             fallPrev,
  output logic             clearLvl,
  output logic             pulseQ,
  output logic             pulseQn
);

  localparam int               NSIG     = 3;
  // bit order {clear, fall, rise}; idle levels after reset
  localparam logic [NSIG-1:0]  SYNC_RST = 3'b110;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [NSIG-1:0]  syncOut;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] effWidth;
  logic             qnReg;

  retrig_oneshot_sync #(
    .W      (NSIG),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({clearNIn, trigFallIn, trigRiseIn}),
    .dout(syncOut)
  );

  assign riseLvl  = syncOut[0];
  assign fallLvl  = syncOut[1];
  assign clearLvl = syncOut[2];

  // Edge history: previous-cycle copy of the synchronised triggers.
  always_ff @(posedge clk) begin
    if (rst) begin
      risePrev <= 1'b0;
      fallPrev <= 1'b1;
    end else begin
      risePrev <= riseLvl;
      fallPrev <= fallLvl;
    end
  end

  assign effWidth = (widthIn == '0) ? ONE : widthIn;

  always_comb begin
    if (ctlStb.kill)        cntNext = '0;
    else if (ctlStb.load)   cntNext = effWidth;
    else if (cntQ != '0)    cntNext = cntQ - ONE;
    else                    cntNext = cntQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ  <= '0;
      qnReg <= 1'b1;
    end else begin
      cntQ  <= cntNext;
      qnReg <= (cntNext == '0);
    end
  end

  assign pulseQ  = (cntQ != '0);
  assign pulseQn = qnReg;

endmodule

// File: rtl/retrig_oneshot_ctl.sv
module retrig_oneshot_ctl
  import retrig_oneshot_pkg::*;
(
  input  logic      riseLvl,
  input  logic      risePrev,
  input  logic      fallLvl,
  input  logic      fallPrev,
  input  logic      clearLvl,
  output osStrobe_t ctlStb
);

  logic riseHit;
  logic fallHit;

  // Each edge is qualified by the present level of the opposite input.
  assign riseHit = riseLvl & ~risePrev & fallLvl;
  assign fallHit = ~fallLvl & fallPrev & ~riseLvl;

  always_comb begin
    ctlStb.kill = ~clearLvl;
    ctlStb.load = (riseHit | fallHit) & clearLvl;
  end

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import retrig_oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigRise,
  input  logic             trigFall,
  input  logic             clearN,
  input  logic [CNT_W-1:0] pulseWidth,
  output logic             pulseQ,
  output logic             pulseQn
);

  osStrobe_t ctlStb;
  logic      riseLvl, risePrev, fallLvl, fallPrev, clearLvl;

  retrig_oneshot_dp #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .trigRiseIn(trigRise),
    .trigFallIn(trigFall),
    .clearNIn  (clearN),
    .widthIn   (pulseWidth),
    .ctlStb    (ctlStb),
    .riseLvl   (riseLvl),
    .risePrev  (risePrev),
    .fallLvl   (fallLvl),
    .fallPrev  (fallPrev),
    .clearLvl  (clearLvl),
    .pulseQ    (pulseQ),
    .pulseQn   (pulseQn)
  );

  retrig_oneshot_ctl ctl_i (
    .riseLvl (riseLvl),
    .risePrev(risePrev),
    .fallLvl (fallLvl),
    .fallPrev(fallPrev),
    .clearLvl(clearLvl),
    .ctlStb  (ctlStb)
  );

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pulseQ,
  input logic             pulseQn,
  input logic             clearLvl,
  input logic             loadStb,
  input logic             killStb,
  input logic [CNT_W-1:0] widthIn
);

  logic [CNT_W:0]   runLen;
  logic [CNT_W-1:0] capW;

  always_ff @(posedge clk) begin
    if (rst) begin
      runLen <= '0;
      capW   <= '0;
    end else if (loadStb && !killStb) begin
      runLen <= (CNT_W+1)'(1);
      capW   <= (widthIn == '0) ? CNT_W'(1) : widthIn;
    end else if (pulseQ) begin
      runLen <= runLen + 1'b1;
    end
  end

  // R10
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    pulseQn == !pulseQ);

  // R7
  clear_ends_chk: assert property (@(posedge clk) disable iff (rst)
    !clearLvl |=> !pulseQ);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !clearLvl |-> !loadStb);

  // R2
  load_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (loadStb && !killStb) |=> pulseQ);

  // R4
  no_spont_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulseQ && !loadStb) |=> !pulseQ);

  // R5
  width_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pulseQ |-> (runLen != '0 && runLen <= {1'b0, capW}));

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .pulseQ  (pulseQ),
  .pulseQn (pulseQn),
  .clearLvl(clearLvl),
  .loadStb (ctlStb.load),
  .killStb (ctlStb.kill),
  .widthIn (pulseWidth)
);

// File: tb/retrig_oneshot_tb_top.sv
`timescale 1ns/1ps
module retrig_oneshot_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        trigRise, trigFall, clearN;
  logic [15:0] pulseWidth;
  logic        pulseQ, pulseQn;

  int nChecks = 0;
  int nErr    = 0;
  int first, cnt, expw, falls;
  logic lastQ;

  always #4 clk = ~clk;

  retrig_oneshot #(.CNT_W(16), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .trigRise(trigRise), .trigFall(trigFall),
    .clearN(clearN), .pulseWidth(pulseWidth),
    .pulseQ(pulseQ), .pulseQn(pulseQn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Samples n negedges; records first high sample index and high count.
  task automatic watch(input int n, output int f, output int c);
    f = -1; c = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk(pulseQn == !pulseQ, "R10 complement", int'(pulseQn), int'(!pulseQ));
      if (pulseQ) begin
        if (f < 0) f = k;
        c++;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    rst = 1'b1; trigRise = 1'b0; trigFall = 1'b1; clearN = 1'b1; pulseWidth = 16'd4;
    repeat (3) @(negedge clk);
    chk(pulseQ == 1'b0 && pulseQn == 1'b1, "R1 reset idle", int'(pulseQ), 0);
    rst = 1'b0;
    watch(6, first, cnt);
    chk(cnt == 0, "R1 idle after reset", cnt, 0);

    // Rising-edge trigger sweep over widths (R2, R5)
    for (int w = 0; w <= 6; w++) begin
      pulseWidth = 16'(w);
      expw = (w == 0) ? 1 : w;
      trigRise = 1'b1;
      watch(expw + 6, first, cnt);
      chk(first == 3, "R2 start latency", first, 3);
      chk(cnt == expw, "R5 width rise", cnt, expw);
      trigRise = 1'b0;
      watch(6, first, cnt);
      chk(cnt == 0, "R2 falling edge ignored", cnt, 0);
    end

    // Falling-edge trigger sweep over widths (R3, R5)
    for (int w = 0; w <= 6; w++) begin
      pulseWidth = 16'(w);
      expw = (w == 0) ? 1 : w;
      trigFall = 1'b0;
      watch(expw + 6, first, cnt);
      chk(first == 3, "R3 start latency", first, 3);
      chk(cnt == expw, "R5 width fall", cnt, expw);
      trigFall = 1'b1;
      watch(6, first, cnt);
      chk(cnt == 0, "R3 rising edge ignored", cnt, 0);
    end

    // Inhibit combinations (R4)
    pulseWidth = 16'd3;
    trigRise = 1'b1;
    watch(10, first, cnt);
    chk(cnt == 3, "R4 setup pulse", cnt, 3);
    trigFall = 1'b0;
    watch(8, first, cnt);
    chk(cnt == 0, "R4 fall inhibited while rise high", cnt, 0);
    trigRise = 1'b0;
    watch(8, first, cnt);
    chk(cnt == 0, "R4 rise falling with fall low", cnt, 0);
    trigRise = 1'b1;
    watch(8, first, cnt);
    chk(cnt == 0, "R4 rise inhibited while fall low", cnt, 0);
    trigFall = 1'b1;
    watch(8, first, cnt);
    chk(cnt == 0, "R4 fall rising", cnt, 0);
    trigRise = 1'b0;
    watch(8, first, cnt);
    chk(cnt == 0, "R4 return to idle", cnt, 0);

    // Retrigger mid-pulse (R6): spacing 4, width 6 -> 10 cycles
    pulseWidth = 16'd6;
    first = -1; cnt = 0;
    trigRise = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (pulseQ) begin if (first < 0) first = k; cnt++; end
      if (k == 2) trigRise = 1'b0;
      if (k == 4) trigRise = 1'b1;
    end
    chk(first == 3, "R6 retrigger start", first, 3);
    chk(cnt == 10, "R6 retrigger length", cnt, 10);
    trigRise = 1'b0;
    watch(6, first, cnt);

    // Retrigger on the expiring cycle (R6): width 4, spacing 4 -> 8, one fall
    pulseWidth = 16'd4;
    first = -1; cnt = 0; falls = 0; lastQ = 1'b0;
    trigRise = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (lastQ && !pulseQ) falls++;
      lastQ = pulseQ;
      if (pulseQ) begin if (first < 0) first = k; cnt++; end
      if (k == 1) trigRise = 1'b0;
      if (k == 4) trigRise = 1'b1;
    end
    chk(cnt == 8, "R6 boundary length", cnt, 8);
    chk(falls == 1, "R6 boundary no gap", falls, 1);
    trigRise = 1'b0;
    watch(6, first, cnt);

    // Clear cuts a pulse (R7): width 10, clear at 5 -> highs 3..7
    pulseWidth = 16'd10;
    first = -1; cnt = 0;
    trigRise = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (pulseQ) begin if (first < 0) first = k; cnt++; end
      if (k == 7) chk(pulseQ == 1'b1, "R7 still high before clear lands", int'(pulseQ), 1);
      if (k == 8) chk(pulseQ == 1'b0 && pulseQn == 1'b1, "R7 clear lands", int'(pulseQ), 0);
      if (k == 5) clearN = 1'b0;
    end
    chk(cnt == 5, "R7 clear truncates", cnt, 5);

    // Triggers ignored while clear low, no pulse on release (R8)
    trigRise = 1'b0;
    watch(4, first, cnt);
    trigRise = 1'b1;
    watch(10, first, cnt);
    chk(cnt == 0, "R8 trigger during clear", cnt, 0);
    clearN = 1'b1;
    watch(10, first, cnt);
    chk(cnt == 0, "R8 release no pulse", cnt, 0);
    trigRise = 1'b0;
    watch(6, first, cnt);

    // Clear and trigger in the same cycle (R9)
    clearN = 1'b0; trigRise = 1'b1;
    watch(10, first, cnt);
    chk(cnt == 0, "R9 clear wins", cnt, 0);
    clearN = 1'b1;
    watch(8, first, cnt);
    chk(cnt == 0, "R9 release after tie", cnt, 0);
    trigRise = 1'b0;
    watch(6, first, cnt);
    pulseWidth = 16'd2;
    trigRise = 1'b1;
    watch(10, first, cnt);
    chk(first == 3 && cnt == 2, "R9 recovers", cnt, 2);
    trigRise = 1'b0;
    watch(6, first, cnt);

    // Reset in mid-pulse (R1): width 10, reset at 5 -> highs 3..5
    pulseWidth = 16'd10;
    first = -1; cnt = 0;
    trigRise = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (pulseQ) begin if (first < 0) first = k; cnt++; end
      if (k == 5) begin rst = 1'b1; trigRise = 1'b0; end
      if (k == 7) rst = 1'b0;
    end
    chk(cnt == 3, "R1 reset ends pulse", cnt, 3);
    chk(pulseQ == 1'b0 && pulseQn == 1'b1, "R1 idle after mid reset", int'(pulseQ), 0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule